// File: doc/BRIEF.md
# Block-Buffered Flash Write Controller

This block sequences writes into a byte-addressed non-volatile memory model. The memory is organised as pages of 256 bytes, and each page holds eight blocks of 32 bytes. A host streams single-byte writes into a one-block staging buffer. A commit command then programs the staged bytes into the array in a single operation. While that operation runs, a busy flag stays high for a fixed programming time, counted in clock cycles. The array itself is a register file inside the block that stands in for the real cells.

Each page has its own protection input. A commit aimed at a protected page, or at a page beyond the configured page count, is refused with a one-cycle fault pulse. A sticky read lock makes every external read return `8'hFF` and flag the denial. The internal execution read port keeps being served while the lock is set. Only a full-array erase clears the lock, and that erase also sets every byte to `8'hFF`.

The byte write channel uses valid/ready but never applies back-pressure. `wr_ready` is tied high, so every beat presented with `wr_valid` is consumed in that cycle. A beat is either stored in the buffer or discarded, and a discarded beat is reported on `wr_err` one cycle later.

Top module: `bfw_ctrl`

## Requirements
- R1: An address is decoded as follows: bits 15:8 give the page, bits 7:5 give the block within the page, and bits 4:0 give the byte within the block. An accepted byte lands at exactly that location when its block is programmed.
- R2: At program time, only the bytes written since the last buffer clear replace array contents. Every other byte of the block keeps its previous value.
- R3: A successful commit raises `busy` on the next cycle. `busy` stays high for exactly PROG_CYCLES cycles. In the cycle after `busy` falls, `done` is high for one cycle, the new data becomes readable, and the buffer is empty.
- R4: A write beat is discarded, and `wr_err` pulses in the next cycle, in any of these cases: `busy` is high, `cmd_commit` is high in the same cycle, or `cmd_erase` is high in the same cycle.
- R5: The first accepted byte after a buffer clear latches the block, which is address bits 15:5. A later byte with different bits 15:5 is discarded with `wr_err` until the next clear.
- R6: A commit whose page has its `page_prot` bit set gives a one-cycle `fault` in the next cycle. In that case `busy` stays low, the array is not changed, and the buffer is cleared.
- R7: A commit whose page index is NUM_PAGES or higher behaves the same as a protected commit. A read from such an address returns `8'hFF`.
- R8: While the lock is set, an external read returns `8'hFF` and `ext_rd_denied` is high alongside `ext_rd_rvalid`. The execution port still returns the stored data.
- R9: `cmd_lock` sets the lock, and the lock survives commits. Only an erase accepted while idle clears it, and that erase sets every byte to `8'hFF` and empties the buffer. If `cmd_lock` and an accepted erase arrive in the same cycle, the lock stays set. An erase while busy is ignored.
- R10: Both read ports return the data for the address sampled at a clock edge one cycle later. `ext_rd_rvalid` follows `ext_rd_valid` with a one-cycle delay.
- R11: In these cases nothing happens (no busy, no fault, no done): a commit while busy, a commit while the buffer is empty, or a commit in the same cycle as an accepted erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte write beat offered |
| wr_ready | output | 1 | Always high: every beat is consumed |
| wr_addr | input | 16 | Byte address of the beat |
| wr_data | input | 8 | Byte value |
| cmd_commit | input | 1 | Program the staged block |
| cmd_erase | input | 1 | Erase the whole array and clear the lock |
| cmd_lock | input | 1 | Set the read lock |
| page_prot | input | NUM_PAGES | Per-page write protection |
| ext_rd_valid | input | 1 | External read request |
| ext_rd_addr | input | 16 | External read address |
| ext_rd_rvalid | output | 1 | External read response valid |
| ext_rd_data | output | 8 | External read data |
| ext_rd_denied | output | 1 | External read was refused by the lock |
| ex_rd_addr | input | 16 | Execution port read address |
| ex_rd_data | output | 8 | Execution port read data |
| busy | output | 1 | Block programming in progress |
| done | output | 1 | One-cycle pulse at the end of programming |
| fault | output | 1 | One-cycle pulse for a refused commit |
| wr_err | output | 1 | One-cycle pulse for a discarded beat |

## Verification
Each result is due at a fixed offset from the edge that samples its stimulus:
- `wr_err`, `fault`, the read data and the start of `busy` appear one cycle after that edge.
- `done` and the new array contents appear PROG_CYCLES+1 cycles after the commit edge.

A behavioural model in the bench applies the same edge-by-edge rules to its own arrays and counters. It is compared with every output on every falling edge, so a result that comes a cycle early or a cycle late is caught as a mismatch. Directed phases drive each corner case in turn: partial blocks, foreign blocks, protected and out-of-range pages, lock, and erase while busy.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int ADDR_W    = 16;
  localparam int OFS_W     = 5;
  localparam int BSEL_W    = 3;
  localparam int PAGE_LSB  = OFS_W + BSEL_W;
  localparam int BLK_BYTES = 1 << OFS_W;
  localparam int PAGE_BYTES = 1 << PAGE_LSB;
  localparam int TAG_W     = ADDR_W - OFS_W;
  localparam int PG_W      = ADDR_W - PAGE_LSB;

  typedef logic [7:0]       byte_t;
  typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/bfw_buffer.sv
module bfw_buffer
  import bfw_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [ADDR_W-1:0]            addr,
  input  byte_t                        data,
  input  logic                         clear,
  output logic [BLK_BYTES-1:0][7:0]    bytes,
  output logic [BLK_BYTES-1:0]         mask,
  output tag_t                         tag
);
  logic [OFS_W-1:0] ofs;
  assign ofs = addr[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      tag  <= '0;
    end else if (clear) begin
      mask <= '0;
    end else if (load) begin
      mask[ofs] <= 1'b1;
      tag       <= addr[ADDR_W-1:OFS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (load) bytes[ofs] <= data;
  end

  // R5
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && (mask != '0)) |=> (tag == $past(tag)));
endmodule

// File: rtl/bfw_timer.sv
module bfw_timer #(
  parameter int PROG_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(PROG_CYCLES - 1);
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/bfw_array.sv
module bfw_array
  import bfw_pkg::*;
#(
  parameter int NUM_PAGES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog,
  input  tag_t                      prog_tag,
  input  logic [BLK_BYTES-1:0][7:0] prog_bytes,
  input  logic [BLK_BYTES-1:0]      prog_mask,
  input  logic                      erase,
  input  logic                      lock_set,
  input  logic                      ext_rd_valid,
  input  logic [ADDR_W-1:0]         ext_rd_addr,
  output logic                      ext_rd_rvalid,
  output byte_t                     ext_rd_data,
  output logic                      ext_rd_denied,
  input  logic [ADDR_W-1:0]         ex_rd_addr,
  output byte_t                     ex_rd_data
);
  localparam int DEPTH = NUM_PAGES * PAGE_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  byte_t            mem [DEPTH];
  logic             lock_q;
  logic             ext_in, ex_in;
  logic [IDX_W-1:0] base;

  assign ext_in = int'(ext_rd_addr[ADDR_W-1:PAGE_LSB]) < NUM_PAGES;
  assign ex_in  = int'(ex_rd_addr[ADDR_W-1:PAGE_LSB]) < NUM_PAGES;
  assign base   = IDX_W'({prog_tag, {OFS_W{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      lock_q        <= 1'b0;
      ext_rd_rvalid <= 1'b0;
      ext_rd_denied <= 1'b0;
      ext_rd_data   <= 8'hFF;
      ex_rd_data    <= 8'hFF;
    end else begin
      ext_rd_rvalid <= ext_rd_valid;
      ext_rd_denied <= ext_rd_valid && lock_q;
      ext_rd_data   <= (lock_q || !ext_in) ? 8'hFF : mem[ext_rd_addr[IDX_W-1:0]];
      ex_rd_data    <= ex_in ? mem[ex_rd_addr[IDX_W-1:0]] : 8'hFF;
      if (erase) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (prog) begin
        for (int b = 0; b < BLK_BYTES; b++)
          if (prog_mask[b]) mem[base + IDX_W'(b)] <= prog_bytes[b];
      end
      if (lock_set)   lock_q <= 1'b1;
      else if (erase) lock_q <= 1'b0;
    end
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !erase) |=> lock_q);
  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd_valid |=> ext_rd_rvalid);
endmodule

// File: rtl/bfw_ctrl.sv
module bfw_ctrl
  import bfw_pkg::*;
#(
  parameter int NUM_PAGES   = 8,
  parameter int CLK_HZ      = 200_000_000,
  parameter int PROG_CYCLES = CLK_HZ / 400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [15:0]          wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 cmd_commit,
  input  logic                 cmd_erase,
  input  logic                 cmd_lock,
  input  logic [NUM_PAGES-1:0] page_prot,
  input  logic                 ext_rd_valid,
  input  logic [15:0]          ext_rd_addr,
  output logic                 ext_rd_rvalid,
  output logic [7:0]           ext_rd_data,
  output logic                 ext_rd_denied,
  input  logic [15:0]          ex_rd_addr,
  output logic [7:0]           ex_rd_data,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic                 wr_err
);
  localparam int PI_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [BLK_BYTES-1:0][7:0] buf_bytes;
  logic [BLK_BYTES-1:0]      buf_mask;
  tag_t                      buf_tag;
  logic                      buf_empty, tag_hit, wr_load;
  logic                      erase_ok, commit_req, page_bad, start, finish, clear;
  logic [PG_W-1:0]           commit_page;

  assign wr_ready    = 1'b1;
  assign buf_empty   = (buf_mask == '0);
  assign tag_hit     = (wr_addr[ADDR_W-1:OFS_W] == buf_tag);
  assign erase_ok    = cmd_erase && !busy;
  assign wr_load     = wr_valid && !busy && !cmd_commit && !cmd_erase && (buf_empty || tag_hit);
  assign commit_req  = cmd_commit && !busy && !cmd_erase && !buf_empty;
  assign commit_page = buf_tag[TAG_W-1:BSEL_W];
  assign page_bad    = (int'(commit_page) >= NUM_PAGES) || page_prot[commit_page[PI_W-1:0]];
  assign start       = commit_req && !page_bad;
  assign clear       = finish || (commit_req && page_bad) || erase_ok;

  bfw_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .addr(wr_addr), .data(wr_data),
    .clear(clear), .bytes(buf_bytes), .mask(buf_mask), .tag(buf_tag)
  );

  bfw_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .finish(finish), .done(done)
  );

  bfw_array #(.NUM_PAGES(NUM_PAGES)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog(finish), .prog_tag(buf_tag),
    .prog_bytes(buf_bytes), .prog_mask(buf_mask), .erase(erase_ok), .lock_set(cmd_lock),
    .ext_rd_valid(ext_rd_valid), .ext_rd_addr(ext_rd_addr), .ext_rd_rvalid(ext_rd_rvalid),
    .ext_rd_data(ext_rd_data), .ext_rd_denied(ext_rd_denied),
    .ex_rd_addr(ex_rd_addr), .ex_rd_data(ex_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault  <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      fault  <= commit_req && page_bad;
      wr_err <= wr_valid && !wr_load;
    end
  end

  // R4
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> wr_err);
  // R6
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);
  // R6
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
endmodule

// File: tb/tb_bfw_ctrl.sv
module tb_bfw_ctrl;
  localparam int NP    = 4;
  localparam int PROG  = 20;
  localparam int DEPTH = NP * 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, cmd_commit = 0, cmd_erase = 0, cmd_lock = 0, ext_rd_valid = 0;
  logic [15:0] wr_addr = 0, ext_rd_addr = 0, ex_rd_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [NP-1:0] page_prot = 0;
  logic wr_ready, ext_rd_rvalid, ext_rd_denied, busy, done, fault, wr_err;
  logic [7:0] ext_rd_data, ex_rd_data;

  always #2.5 clk = ~clk;

  bfw_ctrl #(.NUM_PAGES(NP), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_commit(cmd_commit), .cmd_erase(cmd_erase), .cmd_lock(cmd_lock),
    .page_prot(page_prot), .ext_rd_valid(ext_rd_valid), .ext_rd_addr(ext_rd_addr),
    .ext_rd_rvalid(ext_rd_rvalid), .ext_rd_data(ext_rd_data), .ext_rd_denied(ext_rd_denied),
    .ex_rd_addr(ex_rd_addr), .ex_rd_data(ex_rd_data), .busy(busy), .done(done),
    .fault(fault), .wr_err(wr_err)
  );

  // behavioural reference state
  int m_mem [DEPTH];
  int m_buf [32];
  bit [31:0] m_mask;
  int m_tag, m_cnt;
  bit m_busy, m_lock;
  bit e_rvalid, e_denied, e_done, e_fault, e_err;
  int e_ext, e_ex;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;
  string cur_req = "R10 reset";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_mask = 0; m_tag = 0; m_cnt = 0; m_busy = 0; m_lock = 0;
      e_rvalid = 0; e_denied = 0; e_done = 0; e_fault = 0; e_err = 0;
      e_ext = 8'hFF; e_ex = 8'hFF;
    end else begin
      automatic bit busy0 = m_busy;
      automatic bit lock0 = m_lock;
      automatic bit empty = (m_mask == 0);
      automatic int ea = ext_rd_addr, xa = ex_rd_addr, wa = wr_addr;
      automatic bit erase = cmd_erase && !busy0;
      automatic bit commit = cmd_commit && !busy0 && !cmd_erase && !empty;
      automatic bit acc = wr_valid && !busy0 && !cmd_commit && !cmd_erase &&
                          (empty || (wa >> 5) == m_tag);
      e_rvalid = ext_rd_valid;
      e_denied = ext_rd_valid && lock0;
      e_ext = (lock0 || (ea >> 8) >= NP) ? 8'hFF : m_mem[ea];
      e_ex  = ((xa >> 8) >= NP) ? 8'hFF : m_mem[xa];
      e_err = wr_valid && !acc;
      e_fault = 0;
      e_done = 0;
      if (busy0) begin
        if (m_cnt == 0) begin
          for (int b = 0; b < 32; b++)
            if (m_mask[b]) m_mem[m_tag * 32 + b] = m_buf[b];
          m_mask = 0; m_busy = 0; e_done = 1;
        end else m_cnt--;
      end
      if (commit) begin
        automatic int pg = m_tag >> 3;
        if (pg >= NP || page_prot[pg]) begin e_fault = 1; m_mask = 0; end
        else begin m_busy = 1; m_cnt = PROG - 1; end
      end
      if (erase) begin
        foreach (m_mem[i]) m_mem[i] = 8'hFF;
        m_lock = 0; m_mask = 0;
      end
      if (cmd_lock) m_lock = 1;
      if (acc) begin
        m_buf[wa & 31] = wr_data;
        m_mask[wa & 31] = 1'b1;
        m_tag = wa >> 5;
      end
    end
  end

  task automatic cmp(string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    cmp("wr_ready", wr_ready, 1);
    cmp("busy", busy, m_busy);
    cmp("done", done, e_done);
    cmp("fault", fault, e_fault);
    cmp("wr_err", wr_err, e_err);
    cmp("ext_rd_rvalid", ext_rd_rvalid, e_rvalid);
    cmp("ext_rd_denied", ext_rd_denied, e_denied);
    cmp("ext_rd_data", ext_rd_data, e_ext);
    cmp("ex_rd_data", ex_rd_data, e_ex);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(int a, int d);
    wr_valid = 1; wr_addr = 16'(a); wr_data = 8'(d); cyc(); wr_valid = 0;
  endtask
  task automatic commit();
    cmd_commit = 1; cyc(); cmd_commit = 0;
  endtask
  task automatic rd(int a);
    ext_rd_valid = 1; ext_rd_addr = 16'(a); ex_rd_addr = 16'(a); cyc(); ext_rd_valid = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired during %s", cur_req);
    summary();
  end

  initial begin
    cyc(3);
    cmp_on = 1;            // R10 reset values checked in reset
    cyc(2);
    rst_n = 1;
    cyc(2);

    cur_req = "R1 R2 R3";  // fill part of page 1 block 1, program, read back
    wr(16'h0125, 8'h5A); wr(16'h013F, 8'hC3); wr(16'h0120, 8'h11);
    commit(); cyc(PROG + 3);
    for (int a = 16'h011E; a < 16'h0142; a++) rd(a);
    cur_req = "R2";        // partial overwrite keeps other bytes
    wr(16'h0126, 8'h77); commit(); cyc(PROG + 3);
    for (int a = 16'h0120; a < 16'h0128; a++) rd(a);

    cur_req = "R4";        // beats during busy and with commit are dropped
    wr(16'h0040, 8'h01); commit();
    wr(16'h0041, 8'h02); wr(16'h0042, 8'h03);
    cyc(PROG + 3);
    wr_valid = 1; wr_addr = 16'h0043; wr_data = 8'h04; cmd_commit = 1; cyc();
    wr_valid = 0; cmd_commit = 0; cyc(PROG + 3);
    for (int a = 16'h0040; a < 16'h0045; a++) rd(a);

    cur_req = "R5";        // foreign block rejected until clear
    wr(16'h0200, 8'hA0); wr(16'h0220, 8'hA1); wr(16'h0201, 8'hA2);
    commit(); cyc(PROG + 3);
    rd(16'h0200); rd(16'h0201); rd(16'h0220);

    cur_req = "R6";        // protected page refused, buffer cleared
    page_prot = 4'b0100;
    wr(16'h0210, 8'hEE); commit(); cyc(2);
    rd(16'h0210);
    wr(16'h0300, 8'h3C); commit(); cyc(PROG + 3); rd(16'h0300);
    page_prot = 4'b0000;

    cur_req = "R7";        // page beyond count
    wr(16'h0500, 8'h99); commit(); cyc(2); rd(16'h0500); rd(16'h07FF);

    cur_req = "R11";       // empty commit and commit while busy
    commit(); cyc(2);
    wr(16'h0060, 8'h66); commit(); cyc(3); commit(); cyc(PROG + 3);
    rd(16'h0060);

    cur_req = "R8";        // lock denies external reads only
    cmd_lock = 1; cyc(); cmd_lock = 0;
    rd(16'h0125); rd(16'h0060); rd(16'h0300);

    cur_req = "R9";        // lock sticky, erase while busy ignored, erase clears
    wr(16'h0080, 8'h18); commit(); cyc(2);
    cmd_erase = 1; cyc(); cmd_erase = 0;
    cyc(PROG + 3); rd(16'h0080); rd(16'h0125);
    wr(16'h00A0, 8'h42);
    cmd_erase = 1; cyc(); cmd_erase = 0; cyc(2);
    rd(16'h0125); rd(16'h0080); rd(16'h0060);
    commit(); cyc(2);      // buffer was emptied by erase
    cmd_erase = 1; cmd_lock = 1; cyc(); cmd_erase = 0; cmd_lock = 0;
    rd(16'h0125);
    cmd_erase = 1; cyc(); cmd_erase = 0; rd(16'h0125);

    cyc(4);
    summary();
  end
endmodule